// File: doc/BRIEF.md
# Vector State Register with Length Control

This block holds the 64-bit state word that governs vector execution: maximum length, current length, element step counters, sub-element steps, remap selectors and enables, ordering flags, a parallelism hint, a remap-persistence flag and a vertical-first flag. It accepts set-length requests and full-word writes. Both are range checked. A request that would store a reserved value is refused, the word is left as it was, and a one-cycle illegal-instruction trap pulse is raised.

For context handling, the word can be exchanged in a single cycle with a per-privilege-level save register or with a vector link copy. The link exchange is used by linking vectorised branches. The selected save register and the link copy can be read at any time. A vector-enable flag reports whether the word is non-zero, and the most-used fields are brought out already decoded.

Bit positions are given in big-endian numbering: numbered bit n of the word is port bit 63-n. Field values read with their lowest-numbered bit as the most significant bit.

Top module: `vstate_ctl`

## Requirements
- R1: After a synchronous active-high reset, the state word, every save register, the link copy and the trap output are all zero.
- R2: The word layout in numbered bits is as follows. Field values are read with their lowest-numbered bit as the most significant bit.
  - Bits 0:6 hold the maximum length and bits 7:13 hold the length.
  - Bits 14:20 hold the source step and bits 21:27 hold the destination step.
  - Bits 28:29 hold the destination sub-step and bits 30:31 hold the source sub-step.
  - Bits 32:41 hold five 2-bit shape selectors and bits 42:46 hold the five remap enables.
  - Bits 47:52 are reserved and are stored as written.
  - Bit 53 is pack and bit 54 is unpack.
  - Bits 55:61 hold the hint, bit 62 is persistence and bit 63 is vertical-first.
  - The decoded outputs show the maximum length, length, both steps, the remap enables, persistence and vertical-first from the stored word.
- R3: A legal set-length request sets the maximum length to the new maximum when one is supplied, otherwise it keeps the stored maximum. It sets the length to the minimum of the requested length and that maximum. All other fields are kept.
- R4: A set-length request is refused with a trap when the requested length exceeds 64, or when a new maximum is supplied that is 0 or exceeds 64. A refused request leaves the word unchanged.
- R5: An accepted set-length request that alters the length or the maximum clears persistence (bit 62). If neither value changes, persistence is kept.
- R6: A full-word write is refused with a trap, leaving the word unchanged, when the maximum exceeds 64, the length exceeds 64, or either step is 64 or more. Otherwise the word is stored as written, except that a length above the written maximum is stored as that maximum.
- R7: The vector-enable output is 1 exactly when the state word is non-zero.
- R8: A privilege exchange with a valid level swaps the state word and that level's save register in one edge. A level number at or above the number of levels has no effect, and its save read-out is zero.
- R9: A link exchange swaps the state word and the link copy in one edge.
- R10: When requests coincide, the priority is privilege exchange, then link exchange, then full-word write, then set-length. Lower-priority requests in that cycle have no effect and raise no trap.
- R11: The trap output is high for exactly the cycle after the edge that refused a request, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sl_req | input | 1 | Set-length request |
| sl_len | input | 8 | Requested length |
| sl_set_max | input | 1 | Request also supplies a new maximum |
| sl_max | input | 8 | New maximum length |
| wr_en | input | 1 | Full-word write strobe |
| wr_word | input | 64 | Full-word write data |
| px_req | input | 1 | Privilege-level exchange request |
| px_lvl | input | 2 | Privilege level to exchange with |
| lx_req | input | 1 | Link exchange request |
| state_q | output | 64 | Current state word |
| vec_on | output | 1 | Vector mode enabled (word non-zero) |
| fld_maxvl | output | 7 | Decoded maximum length |
| fld_vl | output | 7 | Decoded length |
| fld_src | output | 7 | Decoded source step |
| fld_dst | output | 7 | Decoded destination step |
| fld_remap_en | output | 5 | Decoded remap enables |
| fld_persist | output | 1 | Decoded remap persistence |
| fld_vfirst | output | 1 | Decoded vertical-first flag |
| trap_q | output | 1 | Illegal-instruction trap pulse |
| save_q | output | 64 | Save register of level px_lvl |
| link_q | output | 64 | Link copy |

## Verification
An exchange and a set-length request can fall in the same cycle. The bench raises both together in several combinations: a privilege exchange with a trapping set-length request, a link exchange with a full-word write, and a full-word write with a legal set-length request. It also lets random traffic raise several strobes at once. The result is judged against a behavioural model that applies only the winning action. The model requires the state word, the save register and the link copy to show the swap alone, with no trap from the losing request.

// File: rtl/vstate_pkg.sv
package vstate_pkg;
  localparam int WORD_W     = 64;
  localparam int FLD_W      = 7;
  localparam int MAXVL_LO   = 57;
  localparam int VL_LO      = 50;
  localparam int SRC_LO     = 43;
  localparam int DST_LO     = 36;
  localparam int REN_LO     = 17;
  localparam int REN_W      = 5;
  localparam int PERS_BIT   = 1;
  localparam int VFIRST_BIT = 0;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_PRIV,
    ACT_LINK,
    ACT_WRITE,
    ACT_SETLEN
  } act_e;
endpackage

// File: rtl/vstate_setlen.sv
module vstate_setlen
  import vstate_pkg::*;
#(
  parameter int MAX_LEN = 64,
  parameter int REQ_W   = 8
) (
  input  logic [WORD_W-1:0] cur,
  input  logic [REQ_W-1:0]  req_len,
  input  logic              set_max,
  input  logic [REQ_W-1:0]  new_max,
  output logic [WORD_W-1:0] nxt,
  output logic              bad
);
  localparam logic [REQ_W-1:0] LIM = REQ_W'(MAX_LEN);

  logic [REQ_W-1:0] cur_max, cur_vl, eff_max, new_vl;
  logic             changed;

  always_comb begin
    cur_max = REQ_W'(cur[MAXVL_LO +: FLD_W]);
    cur_vl  = REQ_W'(cur[VL_LO +: FLD_W]);
    eff_max = set_max ? new_max : cur_max;
    bad     = (req_len > LIM) || (set_max && ((new_max == '0) || (new_max > LIM)));
    new_vl  = (req_len < eff_max) ? req_len : eff_max;
    changed = (new_vl != cur_vl) || (eff_max != cur_max);
    nxt     = cur;
    nxt[MAXVL_LO +: FLD_W] = eff_max[FLD_W-1:0];
    nxt[VL_LO +: FLD_W]    = new_vl[FLD_W-1:0];
    if (changed) nxt[PERS_BIT] = 1'b0;
  end
endmodule

// File: rtl/vstate_wrchk.sv
module vstate_wrchk
  import vstate_pkg::*;
#(
  parameter int MAX_LEN = 64
) (
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] nxt,
  output logic              bad
);
  localparam logic [FLD_W-1:0] LIM = FLD_W'(MAX_LEN);

  logic [FLD_W-1:0] mx, vl, src, dst;

  always_comb begin
    mx  = din[MAXVL_LO +: FLD_W];
    vl  = din[VL_LO +: FLD_W];
    src = din[SRC_LO +: FLD_W];
    dst = din[DST_LO +: FLD_W];
    bad = (mx > LIM) || (vl > LIM) || (src >= LIM) || (dst >= LIM);
    nxt = din;
    if (vl > mx) nxt[VL_LO +: FLD_W] = mx;
  end
endmodule

// File: rtl/vstate_bank.sv
module vstate_bank #(
  parameter int NLVL  = 3,
  parameter int LVL_W = 2,
  parameter int W     = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [LVL_W-1:0] sel,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout
);
  localparam int DEPTH = 1 << LVL_W;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[sel] <= din;
    end
  end

  assign dout = mem[sel];

  p_bank_swap_r8: assert property (@(posedge clk) disable iff (rst)
    $past(we) |-> mem[$past(sel)] == $past(din));

  p_bank_sel_r8: assert property (@(posedge clk) disable iff (rst)
    we |-> int'(sel) < NLVL);
endmodule

// File: rtl/vstate_ctl.sv
module vstate_ctl
  import vstate_pkg::*;
#(
  parameter int MAX_LEN = 64,
  parameter int NLVL    = 3,
  parameter int REQ_W   = 8,
  localparam int LVL_W  = (NLVL > 1) ? $clog2(NLVL) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sl_req,
  input  logic [REQ_W-1:0]   sl_len,
  input  logic               sl_set_max,
  input  logic [REQ_W-1:0]   sl_max,
  input  logic               wr_en,
  input  logic [WORD_W-1:0]  wr_word,
  input  logic               px_req,
  input  logic [LVL_W-1:0]   px_lvl,
  input  logic               lx_req,
  output logic [WORD_W-1:0]  state_q,
  output logic               vec_on,
  output logic [FLD_W-1:0]   fld_maxvl,
  output logic [FLD_W-1:0]   fld_vl,
  output logic [FLD_W-1:0]   fld_src,
  output logic [FLD_W-1:0]   fld_dst,
  output logic [REN_W-1:0]   fld_remap_en,
  output logic               fld_persist,
  output logic               fld_vfirst,
  output logic               trap_q,
  output logic [WORD_W-1:0]  save_q,
  output logic [WORD_W-1:0]  link_q
);
  localparam logic [LVL_W:0] NLVL_V = (LVL_W + 1)'(NLVL);

  logic [WORD_W-1:0] st_r, lnk_r, sl_nxt, wr_nxt, bank_rd;
  logic              sl_bad, wr_bad, px_ok, trap_r;
  act_e              act;

  vstate_setlen #(.MAX_LEN(MAX_LEN), .REQ_W(REQ_W)) u_setlen (
    .cur(st_r), .req_len(sl_len), .set_max(sl_set_max), .new_max(sl_max),
    .nxt(sl_nxt), .bad(sl_bad)
  );

  vstate_wrchk #(.MAX_LEN(MAX_LEN)) u_wrchk (
    .din(wr_word), .nxt(wr_nxt), .bad(wr_bad)
  );

  vstate_bank #(.NLVL(NLVL), .LVL_W(LVL_W), .W(WORD_W)) u_bank (
    .clk(clk), .rst(rst), .we(act == ACT_PRIV), .sel(px_lvl),
    .din(st_r), .dout(bank_rd)
  );

  assign px_ok = px_req && ({1'b0, px_lvl} < NLVL_V);

  // fixed priority: privilege swap, link swap, word write, set-length
  always_comb begin
    if (rst)         act = ACT_NONE;
    else if (px_ok)  act = ACT_PRIV;
    else if (lx_req) act = ACT_LINK;
    else if (wr_en)  act = ACT_WRITE;
    else if (sl_req) act = ACT_SETLEN;
    else             act = ACT_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_r   <= '0;
      lnk_r  <= '0;
      trap_r <= 1'b0;
    end else begin
      trap_r <= 1'b0;
      case (act)
        ACT_PRIV: st_r <= bank_rd;
        ACT_LINK: begin
          st_r  <= lnk_r;
          lnk_r <= st_r;
        end
        ACT_WRITE:  if (wr_bad) trap_r <= 1'b1; else st_r <= wr_nxt;
        ACT_SETLEN: if (sl_bad) trap_r <= 1'b1; else st_r <= sl_nxt;
        default: ;
      endcase
    end
  end

  assign state_q      = st_r;
  assign vec_on       = |st_r;
  assign fld_maxvl    = st_r[MAXVL_LO +: FLD_W];
  assign fld_vl       = st_r[VL_LO +: FLD_W];
  assign fld_src      = st_r[SRC_LO +: FLD_W];
  assign fld_dst      = st_r[DST_LO +: FLD_W];
  assign fld_remap_en = st_r[REN_LO +: REN_W];
  assign fld_persist  = st_r[PERS_BIT];
  assign fld_vfirst   = st_r[VFIRST_BIT];
  assign trap_q       = trap_r;
  assign save_q       = bank_rd;
  assign link_q       = lnk_r;

  p_trap_keep_r4: assert property (@(posedge clk) disable iff (rst)
    trap_r |-> st_r == $past(st_r));

  p_vl_cap_r6: assert property (@(posedge clk) disable iff (rst)
    fld_vl <= fld_maxvl);

  p_step_rng_r6: assert property (@(posedge clk) disable iff (rst)
    (int'(fld_src) < MAX_LEN) && (int'(fld_dst) < MAX_LEN) && (int'(fld_maxvl) <= MAX_LEN));

  p_persist_clr_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(act == ACT_SETLEN && !sl_bad) &&
     ((fld_vl != $past(fld_vl)) || (fld_maxvl != $past(fld_maxvl)))) |-> !fld_persist);

  p_link_swap_r9: assert property (@(posedge clk) disable iff (rst)
    $past(act == ACT_LINK) |-> (lnk_r == $past(st_r)) && (st_r == $past(lnk_r)));

  p_prio_r10: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_PRIV || act == ACT_LINK) |=> !trap_r);
endmodule

// File: tb/test_vstate_ctl.sv
`timescale 1ns/1ps
module test_vstate_ctl;
  logic        clk, rst;
  logic        sl_req, sl_set_max, wr_en, px_req, lx_req;
  logic [7:0]  sl_len, sl_max;
  logic [63:0] wr_word;
  logic [1:0]  px_lvl;
  logic [63:0] state_q, save_q, link_q;
  logic        vec_on, fld_persist, fld_vfirst, trap_q;
  logic [6:0]  fld_maxvl, fld_vl, fld_src, fld_dst;
  logic [4:0]  fld_remap_en;

  vstate_ctl i_vstate_ctl (
    .clk(clk), .rst(rst), .sl_req(sl_req), .sl_len(sl_len), .sl_set_max(sl_set_max),
    .sl_max(sl_max), .wr_en(wr_en), .wr_word(wr_word), .px_req(px_req), .px_lvl(px_lvl),
    .lx_req(lx_req), .state_q(state_q), .vec_on(vec_on), .fld_maxvl(fld_maxvl),
    .fld_vl(fld_vl), .fld_src(fld_src), .fld_dst(fld_dst), .fld_remap_en(fld_remap_en),
    .fld_persist(fld_persist), .fld_vfirst(fld_vfirst), .trap_q(trap_q),
    .save_q(save_q), .link_q(link_q)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int    checks = 0, fails = 0, cyc_cnt = 0;
  string tag = "R1";

  logic [63:0] m_st, m_lnk;
  logic [63:0] m_sav [4];
  logic        m_trap;

  function automatic logic [63:0] get(logic [63:0] w, int a, int b);
    int n = b - a + 1;
    return (w >> (63 - b)) & ((64'd1 << n) - 64'd1);
  endfunction

  function automatic logic [63:0] put(logic [63:0] w, int a, int b, logic [63:0] v);
    int n = b - a + 1;
    logic [63:0] m = ((64'd1 << n) - 64'd1) << (63 - b);
    return (w & ~m) | ((v << (63 - b)) & m);
  endfunction

  function automatic logic [63:0] mk(logic [63:0] mx, logic [63:0] vl, logic [63:0] src,
                                     logic [63:0] dst, logic [63:0] rsv, logic [63:0] hint,
                                     logic [63:0] pers, logic [63:0] vf);
    logic [63:0] w = 64'd0;
    w = put(w, 0, 6, mx);    w = put(w, 7, 13, vl);
    w = put(w, 14, 20, src); w = put(w, 21, 27, dst);
    w = put(w, 28, 29, 64'd1); w = put(w, 30, 31, 64'd2);
    w = put(w, 32, 41, 64'h2AB); w = put(w, 42, 46, 64'h15);
    w = put(w, 47, 52, rsv); w = put(w, 53, 53, 64'd1);
    w = put(w, 55, 61, hint); w = put(w, 62, 62, pers);
    w = put(w, 63, 63, vf);
    return w;
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      fails++;
      $display("FAIL R1 watchdog got=%0d exp<150000", cyc_cnt);
      summary();
      $finish;
    end
  end

  task automatic chk(bit ok, string t, string what, logic [63:0] a, logic [63:0] e);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s got=%h exp=%h", t, what, a, e);
    end
  endtask

  task automatic model_step();
    logic [63:0] t, mx, vl, em, nv;
    bit bad;
    m_trap = 1'b0;
    if (rst) begin
      m_st = '0; m_lnk = '0;
      for (int i = 0; i < 4; i++) m_sav[i] = '0;
    end else if (px_req && px_lvl < 2'd3) begin
      t = m_st; m_st = m_sav[px_lvl]; m_sav[px_lvl] = t;
    end else if (lx_req) begin
      t = m_st; m_st = m_lnk; m_lnk = t;
    end else if (wr_en) begin
      mx = get(wr_word, 0, 6); vl = get(wr_word, 7, 13);
      bad = (mx > 64'd64) || (vl > 64'd64) || (get(wr_word, 14, 20) >= 64'd64) ||
            (get(wr_word, 21, 27) >= 64'd64);
      if (bad) m_trap = 1'b1;
      else begin
        m_st = wr_word;
        if (vl > mx) m_st = put(m_st, 7, 13, mx);
      end
    end else if (sl_req) begin
      em = sl_set_max ? 64'(sl_max) : get(m_st, 0, 6);
      bad = (sl_len > 8'd64) || (sl_set_max && (sl_max == 8'd0 || sl_max > 8'd64));
      if (bad) m_trap = 1'b1;
      else begin
        nv = (64'(sl_len) < em) ? 64'(sl_len) : em;
        if (nv != get(m_st, 7, 13) || em != get(m_st, 0, 6)) m_st = put(m_st, 62, 62, 64'd0);
        m_st = put(put(m_st, 0, 6, em), 7, 13, nv);
      end
    end
  endtask

  task automatic compare();
    chk(state_q === m_st, tag, "state", state_q, m_st);
    chk(trap_q === m_trap, tag, "trap", 64'(trap_q), 64'(m_trap));
    chk(vec_on === (m_st != 64'd0), "R7", "vec_on", 64'(vec_on), 64'(m_st != 64'd0));
    chk(64'(fld_maxvl) === get(m_st, 0, 6), "R2", "maxvl", 64'(fld_maxvl), get(m_st, 0, 6));
    chk(64'(fld_vl) === get(m_st, 7, 13), "R2", "vl", 64'(fld_vl), get(m_st, 7, 13));
    chk(64'(fld_src) === get(m_st, 14, 20), "R2", "src", 64'(fld_src), get(m_st, 14, 20));
    chk(64'(fld_dst) === get(m_st, 21, 27), "R2", "dst", 64'(fld_dst), get(m_st, 21, 27));
    chk(64'(fld_remap_en) === get(m_st, 42, 46), "R2", "remap_en", 64'(fld_remap_en), get(m_st, 42, 46));
    chk(64'(fld_persist) === get(m_st, 62, 62), "R5", "persist", 64'(fld_persist), get(m_st, 62, 62));
    chk(64'(fld_vfirst) === get(m_st, 63, 63), "R2", "vfirst", 64'(fld_vfirst), get(m_st, 63, 63));
    chk(save_q === m_sav[px_lvl], "R8", "save", save_q, m_sav[px_lvl]);
    chk(link_q === m_lnk, "R9", "link", link_q, m_lnk);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    sl_req = 0; sl_set_max = 0; sl_len = '0; sl_max = '0;
    wr_en = 0; wr_word = '0; px_req = 0; px_lvl = '0; lx_req = 0;
  endtask

  task automatic do_sl(logic [7:0] len, logic sm, logic [7:0] mx, string t);
    idle(); tag = t; sl_req = 1; sl_len = len; sl_set_max = sm; sl_max = mx; cyc();
  endtask

  task automatic do_wr(logic [63:0] w, string t);
    idle(); tag = t; wr_en = 1; wr_word = w; cyc();
  endtask

  task automatic do_px(logic [1:0] l, string t);
    idle(); tag = t; px_req = 1; px_lvl = l; cyc();
  endtask

  task automatic do_lx(string t);
    idle(); tag = t; lx_req = 1; cyc();
  endtask

  initial begin
    idle();
    rst = 1;
    tag = "R1";
    repeat (3) cyc();
    @(negedge clk);
    rst = 0;
    cyc();

    // R3 length clamp against new and stored maximum
    do_sl(8'd10, 1, 8'd16, "R3");
    do_sl(8'd40, 0, 8'd0, "R3");
    do_sl(8'd0, 1, 8'd64, "R3");
    do_sl(8'd64, 0, 8'd0, "R3");

    // R2 / R6 full word with every field populated
    do_wr(mk(32, 20, 5, 7, 64'h2A, 9, 1, 1), "R2");
    // R5 persistence kept when nothing changes, cleared on change
    do_sl(8'd20, 1, 8'd32, "R5");
    do_sl(8'd21, 0, 8'd0, "R5");
    do_wr(mk(32, 21, 5, 7, 0, 3, 1, 0), "R5");
    do_sl(8'd21, 1, 8'd40, "R5");

    // R4 refused set-length requests
    do_sl(8'd65, 0, 8'd0, "R4");
    do_sl(8'd200, 1, 8'd10, "R4");
    do_sl(8'd5, 1, 8'd0, "R4");
    do_sl(8'd5, 1, 8'd65, "R4");
    idle(); tag = "R11"; cyc();

    // R6 refused and truncated writes
    do_wr(mk(70, 3, 0, 0, 0, 0, 0, 0), "R6");
    do_wr(mk(64, 65, 0, 0, 0, 0, 0, 0), "R6");
    do_wr(mk(64, 8, 64, 0, 0, 0, 0, 0), "R6");
    do_wr(mk(64, 8, 0, 64, 0, 0, 0, 0), "R6");
    do_wr(mk(64, 64, 63, 63, 0, 0, 1, 0), "R6");
    do_wr(mk(30, 50, 1, 2, 0, 0, 0, 1), "R6");
    idle(); tag = "R11"; cyc();

    // R8 / R7 privilege exchange, invalid level
    do_px(2'd1, "R8");
    idle(); tag = "R7"; cyc();
    do_wr(mk(12, 4, 0, 0, 0, 0, 0, 0), "R8");
    do_px(2'd2, "R8");
    do_px(2'd1, "R8");
    do_px(2'd3, "R8");
    do_px(2'd2, "R8");

    // R9 link exchange
    do_lx("R9");
    do_lx("R9");

    // R10 collisions
    idle(); tag = "R10"; px_req = 1; px_lvl = 2'd0; sl_req = 1; sl_len = 8'd99; cyc();
    idle(); tag = "R10"; lx_req = 1; wr_en = 1; wr_word = mk(20, 3, 0, 0, 0, 0, 0, 0); cyc();
    idle(); tag = "R10"; wr_en = 1; wr_word = mk(20, 6, 1, 1, 0, 0, 1, 0);
    sl_req = 1; sl_len = 8'd2; cyc();
    idle(); tag = "R10"; lx_req = 1; sl_req = 1; sl_set_max = 1; sl_max = 8'd0; cyc();
    idle(); tag = "R10"; px_req = 1; px_lvl = 2'd3; wr_en = 1; wr_word = mk(90, 0, 0, 0, 0, 0, 0, 0); cyc();

    // random mixed traffic
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] w;
      idle();
      tag = "R10";
      w = {$urandom, $urandom};
      if (($urandom % 4) != 0) begin
        w = put(w, 0, 6, 64'(1 + $urandom % 64));
        w = put(w, 7, 13, 64'($urandom % 70));
        w = put(w, 14, 20, 64'($urandom % 66));
        w = put(w, 21, 27, 64'($urandom % 66));
      end
      sl_req = (($urandom % 3) == 0);
      sl_len = 8'($urandom % 72);
      sl_set_max = $urandom % 2;
      sl_max = 8'($urandom % 70);
      wr_en = (($urandom % 5) == 0);
      wr_word = w;
      px_req = (($urandom % 9) == 0);
      px_lvl = 2'($urandom % 4);
      lx_req = (($urandom % 9) == 0);
      cyc();
    end

    idle(); tag = "R11"; cyc();
    summary();
    $finish;
  end
endmodule